// File: doc/BRIEF.md
# Sequential Integer Divider With Zero Trap

A multi-cycle integer divider for a processor execute stage. A start pulse takes a 32-bit dividend, a 32-bit divisor and a mode bit that selects signed or unsigned division. The unit then works through a radix-2 restoring loop and returns the quotient with a one-cycle completion pulse. Signed division runs on operand magnitudes, and the unit fixes the sign of the quotient at the end. The unit keeps no remainder.

A zero divisor skips the loop. The quotient is forced to zero and completion comes one cycle after acceptance. The unit keeps a sticky divide-by-zero status bit. Every accepted operation rewrites this bit. A one-cycle exception request with the divide-by-zero cause goes out only when the global exception enable is high and the configuration mask bit for this exception is low. The core pipeline owns exception vectoring and the status-register file.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0) the quotient is the floor of dividend over divisor, both read as unsigned. `done_o` rises 32 cycles after the clock edge that accepts the start, and `busy_o` is high from the accepting edge until the edge that raises `done_o`.
- R2: In signed mode (`signed_i`=1) both operands are two's complement, and the quotient is truncated toward zero.
- R3: For a zero divisor the quotient is 0 and `done_o` is high in the cycle right after the accepting edge. `busy_o` never goes high for that operation.
- R4: An accepted operation with a zero divisor sets `dz_flag_o` to 1, and one with a non-zero divisor clears it to 0. In both cases the new value is visible from the accepting edge on. No other event changes the flag.
- R5: `trap_req_o` is a one-cycle pulse that coincides with `done_o` of a zero-divisor operation. It fires only if `exc_en_i` was 1 and `trap_mask_i` was 0 at the accepting edge. A non-zero divisor never raises it.
- R6: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns 0x80000000, clears `dz_flag_o` and raises no trap.
- R7: A start pulse is accepted only when `busy_o` is low. A start while busy changes neither the result, the completion time, `dz_flag_o` nor `trap_req_o`.
- R8: `done_o` is high for exactly one cycle per operation. `quot_o` holds its value until the next completion.
- R9: After synchronous reset (`rst_n`=0 at a clock edge), `quot_o` is 0 and `done_o`, `busy_o`, `dz_flag_o` and `trap_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a division |
| signed_i | input | 1 | 1 selects two's-complement operands |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_en_i | input | 1 | Global exception enable |
| trap_mask_i | input | 1 | 1 suppresses the divide-by-zero exception |
| quot_o | output | 32 | Quotient of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Iteration in progress |
| dz_flag_o | output | 1 | Sticky divide-by-zero status |
| trap_req_o | output | 1 | Exception request, divide-by-zero cause |

## Verification
A wrong iteration count shows up as `done_o` rising early or late, and the cycle-by-cycle model flags it at the first cycle where the pulse differs. A broken partial remainder or a missed sign fix-up leaves the timing right but corrupts `quot_o` in the completion cycle. A status or trap-gating error differs from the model in the cycle right after the accepting edge, because both outputs come straight from registers. A start accepted while busy restarts the counter, which moves `done_o` and changes `quot_o` within the running operation.

// File: rtl/div_pkg.sv
// Package div_pkg
// Shared parameters and types of the sequential divider.
// Assumes nothing beyond IEEE 1800-2017.
package div_pkg;
    localparam int unsigned DIV_W_DEF = 32;

    typedef enum logic [0:0] {
        CORE_IDLE = 1'b0,
        CORE_RUN  = 1'b1
    } core_state_e;
endpackage

// File: rtl/div_sign_prep.sv
// Module div_sign_prep
// Turns the operands into magnitudes and decides whether the quotient
// must be negated. Purely combinational.
// Assumes: W >= 2; in unsigned mode the operands pass through unchanged.
module div_sign_prep #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic         signed_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] mag_dvd_o,
    output logic [W-1:0] mag_dvs_o,
    output logic         neg_q_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic dvd_neg;
    logic dvs_neg;

    // sign of each operand, only meaningful in signed mode
    always_comb begin
        dvd_neg = signed_i & dvd_i[W-1];
        dvs_neg = signed_i & dvs_i[W-1];
    end

    // magnitudes and quotient sign
    always_comb begin
        mag_dvd_o = dvd_neg ? (~dvd_i + ONE) : dvd_i;
        mag_dvs_o = dvs_neg ? (~dvs_i + ONE) : dvs_i;
        neg_q_o   = dvd_neg ^ dvs_neg;
    end
endmodule

// File: rtl/div_iter_core.sv
// Module div_iter_core
// Radix-2 restoring division of unsigned magnitudes, one quotient bit per
// clock over W cycles. fin_o marks the cycle whose edge stores the last
// bit, and quot_raw_o carries the complete quotient in that cycle.
// Assumes: load_i only while idle, and a non-zero divisor on load.
module div_iter_core #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] quot_raw_o
);
    import div_pkg::*;

    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    core_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rem;
    logic [W-1:0]     qsh;
    logic [W-1:0]     dvs;

    logic [W:0]       shifted;
    logic [W:0]       trial;
    logic             fits;
    logic [W-1:0]     rem_nx;
    logic [W-1:0]     q_nx;

    // one restoring step: shift in the next dividend bit and try to subtract
    always_comb begin
        shifted = {rem, qsh[W-1]};
        trial   = shifted - {1'b0, dvs};
        fits    = ~trial[W];
        rem_nx  = fits ? trial[W-1:0] : shifted[W-1:0];
        q_nx    = {qsh[W-2:0], fits};
    end

    // status towards the top
    always_comb begin
        busy_o     = (state == CORE_RUN);
        fin_o      = (state == CORE_RUN) && (cnt == CNT_ONE);
        quot_raw_o = q_nx;
    end

    // state, counter and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CORE_IDLE;
            cnt   <= '0;
            rem   <= '0;
            qsh   <= '0;
            dvs   <= '0;
        end else if (state == CORE_IDLE) begin
            if (load_i) begin
                state <= CORE_RUN;
                cnt   <= CNT_LOAD;
                rem   <= '0;
                qsh   <= dvd_i;
                dvs   <= dvs_i;
            end
        end else begin
            rem <= rem_nx;
            qsh <= q_nx;
            cnt <= cnt - CNT_ONE;
            if (cnt == CNT_ONE) begin
                state <= CORE_IDLE;
            end
        end
    end

    AST_CORE_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CORE_RUN) |-> (cnt != '0)); // R1
    AST_CORE_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> (state == CORE_IDLE)); // R8
    AST_CORE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (state == CORE_IDLE)); // R7
    AST_CORE_NONZERO_DVS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CORE_RUN) |-> (dvs != '0)); // R3
endmodule

// File: rtl/div_zero_trap.sv
// Module div_zero_trap
// Holds the sticky divide-by-zero status and issues the exception
// request, gated by the enable and the inverted mask bit.
// Assumes: accept_i is high for exactly one edge per operation.
module div_zero_trap (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic zero_i,
    input  logic exc_en_i,
    input  logic mask_i,
    output logic dz_o,
    output logic trap_o
);
    // status update on every accepted operation; trap is a single pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dz_o   <= 1'b0;
            trap_o <= 1'b0;
        end else begin
            trap_o <= accept_i & zero_i & exc_en_i & ~mask_i;
            if (accept_i) begin
                dz_o <= zero_i;
            end
        end
    end

    AST_TRAP_NEEDS_DZ: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> dz_o); // R5
    AST_TRAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(exc_en_i && !mask_i)); // R5
    AST_DZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(dz_o)); // R4
    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o && !$past(accept_i) |=> !trap_o); // R5
endmodule

// File: rtl/seq_divider.sv
// Module seq_divider
// Top of the sequential divider. It accepts an operation while idle,
// shortcuts a zero divisor, runs the restoring core otherwise and fixes
// the quotient sign on completion.
// Assumes: synchronous active-low reset; inputs stable around the edge.
module seq_divider #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         exc_en_i,
    input  logic         trap_mask_i,
    output logic [W-1:0] quot_o,
    output logic         done_o,
    output logic         busy_o,
    output logic         dz_flag_o,
    output logic         trap_req_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         accept;
    logic         dvs_zero;
    logic         core_load;
    logic [W-1:0] mag_dvd;
    logic [W-1:0] mag_dvs;
    logic         neg_q;
    logic         neg_q_r;
    logic         core_busy;
    logic         core_fin;
    logic [W-1:0] quot_raw;

    // acceptance: only while no iteration runs
    always_comb begin
        accept    = start_i & ~core_busy;
        dvs_zero  = (divisor_i == '0);
        core_load = accept & ~dvs_zero;
        busy_o    = core_busy;
    end

    div_sign_prep #(.W(W)) u_prep (
        .signed_i  (signed_i),
        .dvd_i     (dividend_i),
        .dvs_i     (divisor_i),
        .mag_dvd_o (mag_dvd),
        .mag_dvs_o (mag_dvs),
        .neg_q_o   (neg_q)
    );

    div_iter_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (core_load),
        .dvd_i      (mag_dvd),
        .dvs_i      (mag_dvs),
        .busy_o     (core_busy),
        .fin_o      (core_fin),
        .quot_raw_o (quot_raw)
    );

    div_zero_trap u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .zero_i   (dvs_zero),
        .exc_en_i (exc_en_i),
        .mask_i   (trap_mask_i),
        .dz_o     (dz_flag_o),
        .trap_o   (trap_req_o)
    );

    // result register, completion pulse and the remembered quotient sign
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_o  <= '0;
            done_o  <= 1'b0;
            neg_q_r <= 1'b0;
        end else begin
            done_o <= (accept & dvs_zero) | core_fin;
            if (core_load) begin
                neg_q_r <= neg_q;
            end
            if (accept && dvs_zero) begin
                quot_o <= '0;
            end else if (core_fin) begin
                quot_o <= neg_q_r ? (~quot_raw + ONE) : quot_raw;
            end
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_ZERO_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_flag_o) |-> (quot_o == '0)); // R3
    AST_BUSY_DZ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(dz_flag_o)); // R4
    AST_ZERO_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i == '0) |=> (!busy_o && done_o)); // R3
    AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o && $past(!core_fin && !accept) |-> $stable(quot_o)); // R8
endmodule

// File: tb/test_seq_divider.sv
`timescale 1ns/1ps
module test_seq_divider;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  dividend_i = '0;
    logic [W-1:0]  divisor_i = '0;
    logic          exc_en_i = 1'b0;
    logic          trap_mask_i = 1'b0;
    logic [W-1:0]  quot_o;
    logic          done_o;
    logic          busy_o;
    logic          dz_flag_o;
    logic          trap_req_o;

    int compared = 0;
    int mismatched = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R9";

    // reference model state
    logic [W-1:0] m_quot = '0;
    logic [W-1:0] m_pend = '0;
    bit m_done = 0, m_busy = 0, m_dz = 0, m_trap = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    seq_divider #(.W(W)) i_seq_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .exc_en_i(exc_en_i),
        .trap_mask_i(trap_mask_i), .quot_o(quot_o), .done_o(done_o),
        .busy_o(busy_o), .dz_flag_o(dz_flag_o), .trap_req_o(trap_req_o)
    );

    function automatic logic [W-1:0] ref_div(logic [W-1:0] a, logic [W-1:0] b, bit s);
        longint sa, sb, q;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end else begin
            sa = longint'({32'd0, a});
            sb = longint'({32'd0, b});
        end
        q = sa / sb;
        return q[W-1:0];
    endfunction

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_quot = '0; m_done = 0; m_busy = 0; m_dz = 0; m_trap = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            m_trap = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_busy = 0; m_quot = m_pend;
                end
            end else if (start_i) begin
                if (divisor_i == '0) begin
                    m_quot = '0; m_done = 1; m_dz = 1;
                    m_trap = exc_en_i && !trap_mask_i;
                end else begin
                    m_dz = 0; m_busy = 1; m_cnt = W;
                    m_pend = ref_div(dividend_i, divisor_i, signed_i);
                end
            end
        end
    end

    task automatic cmp(string name, logic [W-1:0] act, logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual %h expected %h", cur_req, name, $time, act, exp);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (checking && !finished) begin
            cmp("quot_o", quot_o, m_quot);
            cmp("done_o", W'(done_o), W'(m_done));
            cmp("busy_o", W'(busy_o), W'(m_busy));
            cmp("dz_flag_o", W'(dz_flag_o), W'(m_dz));
            cmp("trap_req_o", W'(trap_req_o), W'(m_trap));
        end
    end

    task automatic do_op(logic [W-1:0] a, logic [W-1:0] b, bit s, bit en, bit mk);
        @(negedge clk);
        start_i = 1; dividend_i = a; divisor_i = b; signed_i = s;
        exc_en_i = en; trap_mask_i = mk;
        @(negedge clk);
        start_i = 0;
        repeat (W + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        checking = 1;
        cur_req = "R9";
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_req = "R1";
        do_op(32'd100, 32'd7, 0, 1, 0);
        do_op(32'hFFFF_FFFF, 32'd1, 0, 1, 0);
        do_op(32'd5, 32'd9, 0, 1, 0);
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0);
        for (int i = 0; i < 15; i++) do_op($urandom, $urandom >> (i % 31), 0, 1, 0);

        cur_req = "R2";
        do_op(-32'sd7, 32'sd2, 1, 1, 0);
        do_op(32'sd7, -32'sd2, 1, 1, 0);
        do_op(-32'sd7, -32'sd2, 1, 1, 0);
        do_op(32'h8000_0000, 32'd3, 1, 1, 0);
        for (int i = 0; i < 15; i++) do_op($urandom, $urandom >> (i % 31), 1, 1, 0);

        cur_req = "R3";
        do_op(32'd1234, 32'd0, 0, 0, 0);
        do_op(32'hDEAD_BEEF, 32'd0, 1, 0, 1);
        cur_req = "R4";
        do_op(32'd50, 32'd5, 0, 0, 0);
        cur_req = "R5";
        do_op(32'd9, 32'd0, 0, 1, 0);
        do_op(32'd9, 32'd0, 0, 1, 1);
        do_op(32'd9, 32'd0, 1, 0, 0);
        do_op(32'd9, 32'd3, 0, 1, 0);

        cur_req = "R6";
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0);

        cur_req = "R7";
        @(negedge clk);
        start_i = 1; dividend_i = 32'd1000; divisor_i = 32'd10; signed_i = 0;
        exc_en_i = 1; trap_mask_i = 0;
        @(negedge clk);
        start_i = 0;
        repeat (5) @(negedge clk);
        start_i = 1; dividend_i = 32'd77; divisor_i = 32'd0;
        @(negedge clk);
        start_i = 1; divisor_i = 32'd3;
        repeat (3) @(negedge clk);
        start_i = 0;
        repeat (W) @(negedge clk);

        cur_req = "R8";
        @(negedge clk);
        start_i = 1; dividend_i = 32'd5; divisor_i = 32'd0;
        repeat (3) @(negedge clk);
        start_i = 0;
        repeat (6) @(negedge clk);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            finish_run();
        end
    end
endmodule